// File: doc/BRIEF.md
# Multi-Link Sync Point Controller

This block is a shared control register set used by up to four serial audio bus links. A down-counter clocked from the crystal-derived clock emits a sync-point pulse once every programmed period. The nominal cadence is 4 kHz, so the period value is the crystal frequency in kHz divided by four, minus one: 5999 for a 24 MHz crystal and 9599 for a 38.4 MHz crystal. The period depends only on the crystal and never on the bus clock or the frame rate.

Software writes a new period together with a CPU-sync flag. The new period takes over only when hardware retires that flag, which happens once any link reports that it is powered. Each link has a power-request bit. Its power-acknowledge bit follows that request after a fixed latency, on both the rising and the falling edge. To make several links switch register banks at the same instant, software arms the links concerned and then writes the go bit. The go write clears every arm bit, and each armed link then receives a one-cycle bank-switch strobe on the next sync point.

Access is through a single-cycle 32-bit write port with a combinational read mux. Word 0 is the sync register and word 1 is the link control register.

Top module: `sync_point_ctrl`

## Requirements
- R1: After reset, the sync register (address 0) reads RESET_PERIOD in bits 14:0 and 0 in all other bits. The link control register (address 1) reads 0. No sync pulse appears before the counter has run down.
- R2: The sync pulse is high for one cycle every P+1 cycles, where P is the active period. A period of 0 pulses every cycle.
- R3: A write to the sync register with bit 15 (CPU-sync) at 0 stores the period in bits 14:0, and the period reads back. The active period and the pulse spacing are unchanged.
- R4: A sync write with bit 15 at 1 leaves bit 15 reading 1 for as long as no acknowledge bit is set. Once any acknowledge bit is 1, bit 15 clears on the next cycle, the stored period becomes active and the counter restarts from it.
- R5: In the link control register, bit n is the power request for link n and bit 8+n is its read-only acknowledge. The acknowledge takes the request's value exactly ACK_LAT cycles after the request changed, on both rising and falling edges.
- R6: If a request returns to its old value before the acknowledge has followed, the acknowledge does not change, and a later change starts the full ACK_LAT count again.
- R7: Bits 19:16 of the sync register are read/write arm bits, one per link index. Bit 24 is the go bit and always reads 0. A write with bit 24 at 1 clears all arm bits.
- R8: A go write with at least one arm bit set in the register captures that arm set. On the first sync pulse after the write, bank_switch is high for that one cycle on exactly those links.
- R9: A go write while no arm bit is set produces no bank-switch strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word select: 0 sync register, 1 link control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| sync_pulse | output | 1 | One-cycle sync-point pulse |
| bank_switch | output | NUM_LINKS | Per-link bank-switch strobe |

## Verification
The hardest case to reach is a go write whose strobe must line up with a later sync point. The arm set has to be held across a write that clears the arm bits, and that write must not coincide with a pulse. The stimulus therefore first shortens the period through the CPU-sync handshake. A link is powered up to retire the flag, links are armed and a go write is issued, and the cycle-accurate reference model then checks the strobe on every cycle. The same handshake route reaches the long 5999 period and the zero period. A request that is withdrawn before its acknowledge follows is driven to show the latency count restart.

// File: rtl/sync_pkg.sv
`timescale 1ns/1ps
package sync_pkg;
    localparam int PERIOD_W  = 15;
    localparam int CPU_BIT   = 15;
    localparam int ARM_LSB   = 16;
    localparam int GO_BIT    = 24;
    localparam int ACK_LSB   = 8;
    localparam int MAX_LINKS = 4;

    typedef struct packed {
        logic [PERIOD_W-1:0]  shadow;
        logic                 cpusync;
        logic [MAX_LINKS-1:0] arm;
        logic [MAX_LINKS-1:0] pend;
        logic [PERIOD_W-1:0]  active;
        logic [MAX_LINKS-1:0] req;
    } ctrl_t;
endpackage

// File: rtl/sync_period_timer.sv
`timescale 1ns/1ps
module sync_period_timer #(
    parameter int PERIOD_W     = 15,
    parameter int RESET_PERIOD = 5999
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                load,
    input  logic [PERIOD_W-1:0] load_val,
    output logic                tick
);
    logic [PERIOD_W-1:0] count_d, count_q;

    always_comb begin
        if (load)
            count_d = load_val;
        else if (count_q == '0)
            count_d = period;
        else
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= PERIOD_W'(RESET_PERIOD);
        else        count_q <= count_d;
    end

    assign tick = (count_q == '0);
endmodule

// File: rtl/pwr_ack_tracker.sv
`timescale 1ns/1ps
module pwr_ack_tracker #(
    parameter int ACK_LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack
);
    localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT);

    typedef struct packed {
        logic             ack;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (req == trk_q.ack) begin
            trk_d.cnt = '0;
        end else if (trk_q.cnt == CNT_W'(ACK_LAT - 1)) begin
            trk_d.ack = req;
            trk_d.cnt = '0;
        end else begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ack = trk_q.ack;
endmodule

// File: rtl/sync_point_ctrl.sv
`timescale 1ns/1ps
module sync_point_ctrl
    import sync_pkg::*;
#(
    parameter int NUM_LINKS    = 4,
    parameter int ACK_LAT      = 8,
    parameter int RESET_PERIOD = 5999,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 sync_pulse,
    output logic [NUM_LINKS-1:0] bank_switch
);
    localparam logic [MAX_LINKS-1:0] LINK_MASK = MAX_LINKS'((1 << NUM_LINKS) - 1);
    localparam logic [ADDR_W-1:0]    A_SYNC    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0]    A_LINK    = ADDR_W'(1);

    ctrl_t st_d, st_q;
    logic [MAX_LINKS-1:0] ack_all;
    logic tick, adopt, wr_sync, wr_link;

    // Alias signals observed by the bound checker
    logic [MAX_LINKS-1:0] req_now, ack_now, arm_now;
    logic                 cpusync_now;
    logic [PERIOD_W-1:0]  active_now;

    genvar gi;
    generate
        for (gi = 0; gi < MAX_LINKS; gi++) begin : g_link
            if (gi < NUM_LINKS) begin : g_on
                pwr_ack_tracker #(.ACK_LAT(ACK_LAT)) u_trk (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .req  (st_q.req[gi]),
                    .ack  (ack_all[gi])
                );
            end else begin : g_off
                assign ack_all[gi] = 1'b0;
            end
        end
    endgenerate

    sync_period_timer #(.PERIOD_W(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (st_q.active),
        .load    (adopt),
        .load_val(st_q.shadow),
        .tick    (tick)
    );

    assign adopt   = st_q.cpusync && (|ack_all);
    assign wr_sync = reg_wr && (reg_addr == A_SYNC);
    assign wr_link = reg_wr && (reg_addr == A_LINK);

    always_comb begin
        st_d = st_q;
        if (adopt) begin
            st_d.active  = st_q.shadow;
            st_d.cpusync = 1'b0;
        end
        if (tick)
            st_d.pend = '0;
        if (wr_sync) begin
            st_d.shadow  = reg_wdata[PERIOD_W-1:0];
            st_d.cpusync = reg_wdata[CPU_BIT];
            if (reg_wdata[GO_BIT]) begin
                if (|st_q.arm)
                    st_d.pend = st_q.arm;
                st_d.arm = '0;
            end else begin
                st_d.arm = reg_wdata[ARM_LSB +: MAX_LINKS] & LINK_MASK;
            end
        end
        if (wr_link)
            st_d.req = reg_wdata[MAX_LINKS-1:0] & LINK_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.shadow <= PERIOD_W'(RESET_PERIOD);
            st_q.active <= PERIOD_W'(RESET_PERIOD);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_SYNC) begin
            reg_rdata[PERIOD_W-1:0]           = st_q.shadow;
            reg_rdata[CPU_BIT]                = st_q.cpusync;
            reg_rdata[ARM_LSB +: MAX_LINKS]   = st_q.arm;
        end else if (reg_addr == A_LINK) begin
            reg_rdata[MAX_LINKS-1:0]          = st_q.req;
            reg_rdata[ACK_LSB +: MAX_LINKS]   = ack_all;
        end
    end

    assign sync_pulse  = tick;
    assign bank_switch = tick ? st_q.pend[NUM_LINKS-1:0] : '0;

    assign req_now     = st_q.req;
    assign ack_now     = ack_all;
    assign arm_now     = st_q.arm;
    assign cpusync_now = st_q.cpusync;
    assign active_now  = st_q.active;
endmodule

module sync_point_ctrl_checker
    import sync_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 sync_pulse,
    input logic [NUM_LINKS-1:0] bank_switch,
    input logic [MAX_LINKS-1:0] req_now,
    input logic [MAX_LINKS-1:0] ack_now,
    input logic [MAX_LINKS-1:0] arm_now,
    input logic                 cpusync_now,
    input logic [PERIOD_W-1:0]  active_now
);
    logic sync_wr;
    assign sync_wr = reg_wr && (reg_addr == ADDR_W'(0));

    assert_strobe_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_switch) |-> sync_pulse);

    assert_ack_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_now != $past(ack_now)) |-> ((ack_now ^ $past(ack_now)) & ~(ack_now ^ $past(req_now))) == (ack_now ^ $past(ack_now)));

    assert_go_clears_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_wr && reg_wdata[GO_BIT]) |=> (arm_now == '0));

    assert_cpusync_retires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpusync_now && (|ack_now) && !sync_wr) |=> !cpusync_now);

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && (active_now != '0) && !(cpusync_now && (|ack_now))) |=> !sync_pulse);

    assert_active_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpusync_now && (|ack_now)) |=> $stable(active_now));
endmodule

bind sync_point_ctrl sync_point_ctrl_checker #(
    .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sync_pulse(sync_pulse), .bank_switch(bank_switch),
    .req_now(req_now), .ack_now(ack_now), .arm_now(arm_now),
    .cpusync_now(cpusync_now), .active_now(active_now)
);

// File: tb/test_sync_point_ctrl.sv
`timescale 1ns/1ps
module test_sync_point_ctrl;
    localparam int NL  = 4;
    localparam int LAT = 5;
    localparam int RP  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic sync_pulse;
    logic [NL-1:0] bank_switch;

    int checks = 0;
    int errors = 0;
    int bank_cnt = 0;
    logic [3:0] bank_last = '0;

    always #5 clk = ~clk;

    sync_point_ctrl #(.NUM_LINKS(NL), .ACK_LAT(LAT), .RESET_PERIOD(RP)) i_sync_point_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sync_pulse(sync_pulse), .bank_switch(bank_switch)
    );

    // Behavioural reference model
    logic [14:0] m_shadow, m_active;
    int m_cnt;
    bit m_cpu;
    logic [3:0] m_arm, m_pend, m_req, m_ack;
    int m_lat [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_shadow = 15'(RP); m_active = 15'(RP); m_cnt = RP; m_cpu = 0;
            m_arm = 0; m_pend = 0; m_req = 0; m_ack = 0;
            for (int i = 0; i < 4; i++) m_lat[i] = 0;
        end else begin
            bit adopt;
            bit pulse;
            logic [3:0] old_req;
            adopt = m_cpu && (m_ack != 0);
            pulse = (m_cnt == 0);
            old_req = m_req;
            if (adopt) begin
                m_cnt = int'(m_shadow); m_active = m_shadow; m_cpu = 0;
            end else if (pulse) m_cnt = int'(m_active);
            else m_cnt = m_cnt - 1;
            if (pulse) m_pend = 0;
            for (int i = 0; i < 4; i++) begin
                if (old_req[i] == m_ack[i]) m_lat[i] = 0;
                else if (m_lat[i] == LAT - 1) begin m_ack[i] = old_req[i]; m_lat[i] = 0; end
                else m_lat[i] = m_lat[i] + 1;
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_shadow = reg_wdata[14:0];
                m_cpu = reg_wdata[15];
                if (reg_wdata[24]) begin
                    if (m_arm != 0) m_pend = m_arm;
                    m_arm = 0;
                end else m_arm = reg_wdata[19:16];
            end
            if (reg_wr && reg_addr == 2'd1) m_req = reg_wdata[3:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 sync_pulse vs model", 32'(sync_pulse), 32'(m_cnt == 0));
            chk("R8 bank_switch vs model", 32'(bank_switch), (m_cnt == 0) ? 32'(m_pend) : 32'd0);
            if (bank_switch != 0) begin
                bank_cnt++;
                bank_last = bank_switch;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int n);
        do begin @(posedge clk); #1; end while (!sync_pulse);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!sync_pulse);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int iv;
        int bc;
        waitn(3);
        rst_n = 1'b1;
        #1;
        chk("R1 no pulse after reset", 32'(sync_pulse), 32'd0);
        rd(2'd0, 32'd20, "R1 sync reg reset");
        rd(2'd1, 32'd0, "R1 link reg reset");

        measure(iv); chk("R2 reset period spacing", iv, 21);

        wr(2'd0, 32'h7);
        rd(2'd0, 32'h7, "R3 period reads back");
        measure(iv); chk("R3 spacing unchanged", iv, 21);

        wr(2'd0, 32'h8007);
        rd(2'd0, 32'h8007, "R4 cpusync set");
        waitn(10);
        rd(2'd0, 32'h8007, "R4 cpusync held without ack");

        wr(2'd1, 32'h4);
        waitn(4); rd(2'd1, 32'h004, "R5 ack not yet risen");
        waitn(1); rd(2'd1, 32'h404, "R5 ack risen after latency");
        waitn(1); rd(2'd0, 32'h0007, "R4 cpusync retired");
        measure(iv); chk("R4 new period adopted", iv, 8);

        wr(2'd1, 32'h5);
        waitn(2);
        wr(2'd1, 32'h4);
        waitn(10); rd(2'd1, 32'h404, "R6 withdrawn request no ack");
        wr(2'd1, 32'h5);
        waitn(4); rd(2'd1, 32'h405, "R6 full latency restarts");
        waitn(1); rd(2'd1, 32'h505, "R6 ack after full latency");

        wr(2'd1, 32'h1);
        waitn(4); rd(2'd1, 32'h501, "R5 ack not yet fallen");
        waitn(1); rd(2'd1, 32'h101, "R5 ack fallen after latency");

        wr(2'd0, 32'h0005_0007);
        rd(2'd0, 32'h0005_0007, "R7 arm bits read back");
        bc = bank_cnt;
        wr(2'd0, 32'h0105_0007);
        rd(2'd0, 32'h0000_0007, "R7 go clears arm and reads 0");
        measure(iv);
        chk("R8 one strobe after go", bank_cnt, bc + 1);
        chk("R8 strobe links", 32'(bank_last), 32'h5);

        bc = bank_cnt;
        wr(2'd0, 32'h0100_0007);
        measure(iv); measure(iv);
        chk("R9 go without arm no strobe", bank_cnt, bc);

        wr(2'd0, 32'h000A_0007);
        bc = bank_cnt;
        wr(2'd0, 32'h0100_0007);
        measure(iv);
        chk("R8 arm set taken from register", 32'(bank_last), 32'hA);
        chk("R8 second go strobe count", bank_cnt, bc + 1);

        wr(2'd0, 32'h8000 | 32'd5999);
        measure(iv); chk("R2 24MHz period spacing", iv, 6000);

        wr(2'd0, 32'h8000);
        measure(iv); chk("R2 zero period spacing", iv, 1);
        measure(iv); chk("R2 zero period repeat", iv, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule